// File: doc/BRIEF.md
# Eight-Source Interrupt Controller with Mask and Priority Cutoff

The block collects interrupt requests from eight sources and turns them into a single interrupt line plus a 3-bit vector for a small CPU. Each source line is synchronised and a rising edge on it sets a pending bit. Two independent controls suppress requests. The mask stops an edge from being latched at all. The numeric cutoff leaves latched requests pending but keeps them from raising the interrupt until the cutoff is raised.

Source 0 has the highest priority and source 7 the lowest. The CPU programs the mask and the cutoff through a one-cycle write strobe with a register select. It can read the pending bits at any time. It retires the request it is serving by pulsing an acknowledge, which clears the pending bit named by the current vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_n` is low, the pending bits, `int_o` and `vec_o` are 0. Reset sets all mask bits to 1 and the cutoff to 0, so an edge that arrives after reset and before any mask write is never latched.
- R2: A rising edge on `irq_in[n]` with mask bit n at 0 sets `pending_o[n]` at the third rising clock edge after the input changes. A line that stays high sets its bit only once: after the bit is cleared it stays clear until the line falls and rises again.
- R3: An edge on a line whose mask bit is 1 is never latched. Clearing the mask bit later does not make that edge pending.
- R4: Setting a mask bit to 1 leaves an already pending bit set.
- R5: Pending bit x may raise the interrupt only when x is less than the 4-bit cutoff. A cutoff of 0 blocks every source, a cutoff of 8 to 15 allows all of them, and a cutoff k from 1 to 7 allows sources 0 to k-1.
- R6: `int_o` is 1 exactly when at least one pending bit is allowed by the cutoff.
- R7: `vec_o` gives the lowest index among the pending bits that the cutoff allows, and 0 when there is none.
- R8: `ack` high for one cycle while `int_o` is 1 clears only the pending bit at index `vec_o`, at that clock edge. `ack` while `int_o` is 0 changes nothing.
- R9: If a new edge on a line is latched in the same cycle that `ack` clears that line's bit, the bit stays set.
- R10: A pending bit blocked by the cutoff stays pending. Raising the cutoff later lets it interrupt.
- R11: With `wr_en` high at a clock edge, `wr_sel`=0 loads the mask from `wr_data[7:0]` (bit n belongs to source n), and `wr_sel`=1 loads the cutoff from `wr_data[3:0]`. `wr_data[7:4]` is ignored for the cutoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Asynchronous request lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mask, 1 selects the cutoff |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Acknowledge of the presented vector |
| pending_o | output | 8 | Latched pending bits |
| int_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 3 | Index of the winning request |

## Verification
The bench sweeps pending patterns against cutoff values at each boundary: 0, k, k+1, 8, and values above 8. A design with an off-by-one comparison would then let the source equal to the cutoff interrupt, or lose source 7 at cutoff 8. It checks that an acknowledge while the line is masked off by the cutoff does nothing, and that an acknowledge in the same cycle as a fresh edge keeps the bit. A design that cleared blindly would drop a real request. It also holds a line high across an acknowledge to catch level latching, which would set the bit again. It confirms that reset leaves every source masked and that masking never erases a request that is already pending.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       ack,
  output logic [7:0] pending_o,
  output logic       int_o,
  output logic [2:0] vec_o
);
  localparam int NSRC = 8;
  localparam int VW   = $clog2(NSRC);
  localparam int CW   = 4;

  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic [NSRC-1:0] last_q;
  logic [NSRC-1:0] pending_q, mask_q, allowed, eligible, rise, clr;
  logic [CW-1:0]   cutoff_q;
  logic [VW-1:0]   vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      last_q <= '0;
    end else begin
      sync_q[0] <= irq_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      cutoff_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) cutoff_q <= wr_data[CW-1:0];
      else        mask_q   <= wr_data[NSRC-1:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_allow
      assign allowed[g] = cutoff_q > CW'(g);
    end
  endgenerate

  assign eligible = pending_q & allowed;

  always_comb begin
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (eligible[i]) vec = VW'(i);
  end

  assign clr = (ack && int_o) ? (NSRC'(1) << vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= (pending_q & ~clr) | (rise & ~mask_q);
  end

  assign pending_o = pending_q;
  assign int_o     = |eligible;
  assign vec_o     = vec;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic [7:0] pending_o,
  input logic       int_o,
  input logic [2:0] vec_o,
  input logic [7:0] mask_q,
  input logic [3:0] cutoff_q
);
  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (pending_o == 8'h00 && mask_q == 8'hFF && cutoff_q == 4'h0)); // R1
  AST_MASKED_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending_o & ~$past(pending_o) & $past(mask_q)) == 8'h00)); // R3
  AST_NO_DROP_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((pending_o & $past(pending_o)) == $past(pending_o))); // R4
  AST_ACK_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ($countones($past(pending_o) & ~pending_o) <= 1)); // R8
  AST_VEC_BELOW_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ({1'b0, vec_o} < cutoff_q)); // R5
  AST_VEC_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> pending_o[vec_o]); // R7
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !int_o |-> (vec_o == 3'd0)); // R7
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .pending_o(pending_o),
  .int_o(int_o), .vec_o(vec_o), .mask_q(mask_q), .cutoff_q(cutoff_q)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] irq_in = 0;
  logic       wr_en = 0;
  logic       wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic       ack = 0;
  logic [7:0] pending_o;
  logic       int_o;
  logic [2:0] vec_o;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack(ack), .pending_o(pending_o), .int_o(int_o), .vec_o(vec_o)
  );

  // {pattern[19:12], cutoff[11:8], int[7:4], vec[3:0]}
  localparam logic [19:0] VECS [10] = '{
    20'h00_F_0_0, 20'h80_8_1_7, 20'h80_7_0_0, 20'h24_3_1_2, 20'h24_2_0_0,
    20'hFF_1_1_0, 20'hFF_0_0_0, 20'hF0_5_1_4, 20'h60_6_1_5, 20'h60_9_1_5
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic raise(logic [7:0] p);
    @(negedge clk); irq_in = p;
    repeat (3) @(negedge clk);
    irq_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(1'b1, 8'h0F);
    for (int i = 0; i < 8; i++) if (int_o) pulse_ack();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pending", pending_o, 8'h00);
    check("R1 int", {7'd0, int_o}, 8'h00);
    check("R1 vec", {5'd0, vec_o}, 8'h00);
    rst_n = 1;
    wr(1'b1, 8'h0F);
    raise(8'h01);
    check("R1 default mask blocks", pending_o, 8'h00);
    wr(1'b0, 8'h00);

    // R2 latency and single set on a held line
    @(negedge clk); irq_in = 8'h08;
    @(negedge clk); @(negedge clk);
    check("R2 not yet latched", pending_o, 8'h00);
    @(negedge clk);
    check("R2 latched", pending_o, 8'h08);
    check("R2 vec", {5'd0, vec_o}, 8'h03);
    pulse_ack();
    check("R2 cleared by ack", pending_o, 8'h00);
    repeat (4) @(negedge clk);
    check("R2 held line no reset", pending_o, 8'h00);
    irq_in = 0; repeat (3) @(negedge clk);

    // R3 masked edge
    wr(1'b0, 8'h10);
    raise(8'h10);
    check("R3 masked not latched", pending_o, 8'h00);
    wr(1'b0, 8'h00);
    check("R3 unmask later", pending_o, 8'h00);

    // R4 mask keeps pending
    raise(8'h40);
    wr(1'b0, 8'hFF);
    check("R4 pending kept", pending_o, 8'h40);
    wr(1'b0, 8'h00);

    // R8 ack without interrupt, then selective clear
    raise(8'h02);
    wr(1'b1, 8'h00);
    check("R8 int low", {7'd0, int_o}, 8'h00);
    pulse_ack();
    check("R8 ack ignored", pending_o, 8'h42);
    wr(1'b1, 8'h0F);
    check("R8 vec", {5'd0, vec_o}, 8'h01);
    pulse_ack();
    check("R8 only vec cleared", pending_o, 8'h40);
    check("R8 next vec", {5'd0, vec_o}, 8'h06);
    pulse_ack();
    check("R8 all clear", pending_o, 8'h00);

    // R9 ack and fresh edge together
    raise(8'h04);
    @(negedge clk); irq_in = 8'h04;
    @(negedge clk); @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    check("R9 re-set wins", pending_o, 8'h04);
    irq_in = 0; repeat (3) @(negedge clk);
    pulse_ack();
    check("R9 later clear", pending_o, 8'h00);

    // R11 upper nibble ignored for the cutoff
    raise(8'h08);
    wr(1'b1, 8'hF3);
    check("R11 cutoff 3", {7'd0, int_o}, 8'h00);
    wr(1'b1, 8'hF4);
    check("R11 cutoff 4", {7'd0, int_o}, 8'h01);
    clear_all();

    // R10 blocked request fires after cutoff raised
    raise(8'h80);
    wr(1'b1, 8'h07);
    check("R10 blocked", {7'd0, int_o}, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 still pending", pending_o, 8'h80);
    wr(1'b1, 8'h08);
    check("R10 fires", {7'd0, int_o}, 8'h01);
    check("R10 vec", {5'd0, vec_o}, 8'h07);

    // R5 R6 R7 cutoff and priority sweep
    for (int v = 0; v < 10; v++) begin
      clear_all();
      raise(VECS[v][19:12]);
      wr(1'b1, {4'h0, VECS[v][11:8]});
      check("R10 pending pattern", pending_o, VECS[v][19:12]);
      check("R5 R6 int", {7'd0, int_o}, {4'h0, VECS[v][7:4]});
      check("R7 vec", {5'd0, vec_o}, {4'h0, VECS[v][3:0]});
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule